// File: doc/BRIEF.md
# Shared-Memory Lock and Fence Arbiter

This block arbitrates memory commands from a set of processors that each keep a private store buffer in front of a shared memory. Each processor presents at most one command at a time. The command may be a load, a store, a full fence, a load-only fence, a store-only fence, a lock acquire or a lock release. In every cycle the arbiter finds the commands whose preconditions hold and accepts exactly one of them. The choice rotates so that no eligible processor is starved.

The arbiter holds a single global lock, which is either free or owned by one processor. While the lock is owned, only the owner may complete loads or drain its store buffer; every other processor's loads and drains wait. Acquire, release and full-fence commands wait until the issuer's store buffer reports empty. Together these rules give total-store-order behaviour, with atomic sections bracketed by acquire and release.

A release from a processor that does not own the lock is never accepted. It also sets a sticky error flag, which only reset clears. Memory contents and the store buffers themselves live outside this block. The block sees only each buffer's empty flag, and it returns a drain permit for each buffer.

Top module: `tso_lock_arbiter`

## Requirements
- R1: At most one bit of `cmd_ready_o` is high in any cycle, and only for a processor whose `cmd_valid_i` is high.
- R2: A load (code 3'b000) is accepted only when the lock is free or the issuer owns it.
- R3: A store (3'b001), a load-only fence (3'b011) and a store-only fence (3'b100) are always eligible, regardless of the lock or buffer state, and they change no lock state.
- R4: A full fence (3'b010) is eligible only when the issuer's `wb_empty_i` bit is high.
- R5: A lock acquire (3'b101) is eligible only when the lock is free and the issuer's buffer is empty. Accepting it makes the lock held, with the issuer as owner, from the next cycle. Without an acquire or release the lock state does not change.
- R6: A lock release (3'b110) is eligible only when the issuer owns the lock and its buffer is empty. Accepting it frees the lock from the next cycle.
- R7: `drain_ok_o` is all ones while the lock is free. While the lock is held, it is one-hot on the owner's bit.
- R8: Eligible commands are served round-robin. The search starts at the processor after the last one accepted (processor 0 after reset), so N processors that stay eligible are each served once in N cycles.
- R9: A valid release from a processor that does not own the lock is never accepted. It sets `unlock_err_o` on the next edge, and the flag then stays high until reset.
- R10: The unused code 3'b111 is never accepted.
- R11: After reset the lock is free, `unlock_err_o` is low and the round-robin search starts at processor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | N_CPU | One command pending, per processor |
| cmd_type_i | input | 3*N_CPU | Command code per processor; processor i in bits [3i+2:3i] |
| wb_empty_i | input | N_CPU | Store buffer of processor i is empty |
| cmd_ready_o | output | N_CPU | Command of processor i accepted this cycle |
| drain_ok_o | output | N_CPU | Buffer of processor i may write to memory |
| lock_held_o | output | 1 | Global lock is owned |
| lock_owner_o | output | $clog2(N_CPU) | Index of the owner, valid while held |
| unlock_err_o | output | 1 | Sticky flag for a release by a non-owner |

## Verification
The bound checker watches the safety rules on every cycle: at most one acceptance, no load past a foreign lock, no full fence, acquire or release over a non-empty buffer, the lock state changing only on acquire or release, the drain permit following the owner, and the error flag staying set. Fairness and order cannot be seen from any single cycle. The bench's scenarios cover them: the rotation order, which of several eligible processors wins, buffer emptiness releasing a stalled command, and the error flag's reaction to a foreign release.

// File: rtl/tsoa_pkg.sv
package tsoa_pkg;
  localparam int unsigned CMD_W = 3;
  localparam logic [CMD_W-1:0] CMD_LOAD    = 3'b000;
  localparam logic [CMD_W-1:0] CMD_STORE   = 3'b001;
  localparam logic [CMD_W-1:0] CMD_FENCE_F = 3'b010;
  localparam logic [CMD_W-1:0] CMD_FENCE_L = 3'b011;
  localparam logic [CMD_W-1:0] CMD_FENCE_S = 3'b100;
  localparam logic [CMD_W-1:0] CMD_ACQ     = 3'b101;
  localparam logic [CMD_W-1:0] CMD_REL     = 3'b110;
endpackage

// File: rtl/tsoa_elig.sv
module tsoa_elig
  import tsoa_pkg::*;
#(
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned CPU_ID = 0
) (
  input  logic             valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             wb_empty_i,
  input  logic             held_i,
  input  logic [IDX_W-1:0] owner_i,
  output logic             elig_o,
  output logic             is_acq_o,
  output logic             is_rel_o,
  output logic             bad_rel_o,
  output logic             drain_ok_o
);
  logic mine;
  logic free_or_mine;

  assign mine         = held_i && (owner_i == IDX_W'(CPU_ID));
  assign free_or_mine = !held_i || mine;
  assign drain_ok_o   = free_or_mine;
  assign is_acq_o     = (cmd_i == CMD_ACQ);
  assign is_rel_o     = (cmd_i == CMD_REL);
  assign bad_rel_o    = valid_i && is_rel_o && !mine;

  always_comb begin
    unique case (cmd_i)
      CMD_LOAD:    elig_o = free_or_mine;
      CMD_STORE,
      CMD_FENCE_L,
      CMD_FENCE_S: elig_o = 1'b1;
      CMD_FENCE_F: elig_o = wb_empty_i;
      CMD_ACQ:     elig_o = !held_i && wb_empty_i;
      CMD_REL:     elig_o = mine && wb_empty_i;
      default:     elig_o = 1'b0;
    endcase
    elig_o = elig_o && valid_i;
  end
endmodule

// File: rtl/tsoa_rr_pick.sv
module tsoa_rr_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] gnt_idx_o,
  output logic             gnt_any_o
);
  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    gnt_o     = '0;
    gnt_idx_o = '0;
    gnt_any_o = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % int'(N);
      if (!gnt_any_o && req_i[idx]) begin
        gnt_any_o      = 1'b1;
        gnt_o[idx]     = 1'b1;
        gnt_idx_o      = IDX_W'(idx);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (gnt_any_o)
      ptr_d = (int'(gnt_idx_o) == int'(N) - 1) ? '0 : gnt_idx_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end
endmodule

// File: rtl/tsoa_lock_state.sv
module tsoa_lock_state #(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             give_i,
  input  logic [IDX_W-1:0] take_idx_i,
  input  logic             bad_rel_i,
  output logic             held_o,
  output logic [IDX_W-1:0] owner_o,
  output logic             err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_o  <= 1'b0;
      owner_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (take_i) begin
        held_o  <= 1'b1;
        owner_o <= take_idx_i;
      end else if (give_i) begin
        held_o  <= 1'b0;
      end
      if (bad_rel_i) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/tso_lock_arbiter.sv
module tso_lock_arbiter
  import tsoa_pkg::*;
#(
  parameter int unsigned N_CPU = 4,
  localparam int unsigned IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CPU-1:0]       cmd_valid_i,
  input  logic [CMD_W*N_CPU-1:0] cmd_type_i,
  input  logic [N_CPU-1:0]       wb_empty_i,
  output logic [N_CPU-1:0]       cmd_ready_o,
  output logic [N_CPU-1:0]       drain_ok_o,
  output logic                   lock_held_o,
  output logic [IDX_W-1:0]       lock_owner_o,
  output logic                   unlock_err_o
);
  logic [N_CPU-1:0] elig, is_acq, is_rel, bad_rel;
  logic [IDX_W-1:0] gnt_idx;
  logic             gnt_any;
  logic             take, give;

  for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
    tsoa_elig #(.IDX_W(IDX_W), .CPU_ID(g)) u_elig (
      .valid_i    (cmd_valid_i[g]),
      .cmd_i      (cmd_type_i[g*CMD_W +: CMD_W]),
      .wb_empty_i (wb_empty_i[g]),
      .held_i     (lock_held_o),
      .owner_i    (lock_owner_o),
      .elig_o     (elig[g]),
      .is_acq_o   (is_acq[g]),
      .is_rel_o   (is_rel[g]),
      .bad_rel_o  (bad_rel[g]),
      .drain_ok_o (drain_ok_o[g])
    );
  end

  tsoa_rr_pick #(.N(N_CPU), .IDX_W(IDX_W)) u_pick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (elig),
    .gnt_o     (cmd_ready_o),
    .gnt_idx_o (gnt_idx),
    .gnt_any_o (gnt_any)
  );

  assign take = gnt_any && |(cmd_ready_o & is_acq);
  assign give = gnt_any && |(cmd_ready_o & is_rel);

  tsoa_lock_state #(.IDX_W(IDX_W)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .give_i     (give),
    .take_idx_i (gnt_idx),
    .bad_rel_i  (|bad_rel),
    .held_o     (lock_held_o),
    .owner_o    (lock_owner_o),
    .err_o      (unlock_err_o)
  );
endmodule

// File: rtl/tso_lock_arbiter_chk.sv
module tso_lock_arbiter_chk
  import tsoa_pkg::*;
#(
  parameter int unsigned N_CPU = 4,
  localparam int unsigned IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_CPU-1:0]       cmd_valid_i,
  input logic [CMD_W*N_CPU-1:0] cmd_type_i,
  input logic [N_CPU-1:0]       wb_empty_i,
  input logic [N_CPU-1:0]       cmd_ready_o,
  input logic [N_CPU-1:0]       drain_ok_o,
  input logic                   lock_held_o,
  input logic [IDX_W-1:0]       lock_owner_o,
  input logic                   unlock_err_o
);
  logic load_foreign, fence_dirty, acq_bad, rel_bad, code_bad, acq_gnt, rel_gnt;
  logic [IDX_W-1:0] gidx;
  logic [N_CPU-1:0] owner_hot;

  always_comb begin
    load_foreign = 1'b0; fence_dirty = 1'b0; acq_bad = 1'b0; rel_bad = 1'b0;
    code_bad = 1'b0; acq_gnt = 1'b0; rel_gnt = 1'b0; gidx = '0; owner_hot = '0;
    owner_hot[lock_owner_o] = 1'b1;
    for (int i = 0; i < int'(N_CPU); i++) begin
      logic [CMD_W-1:0] c;
      c = cmd_type_i[i*CMD_W +: CMD_W];
      if (cmd_ready_o[i]) begin
        gidx = IDX_W'(i);
        if (c == CMD_LOAD && lock_held_o && lock_owner_o != IDX_W'(i)) load_foreign = 1'b1;
        if (c == CMD_FENCE_F && !wb_empty_i[i]) fence_dirty = 1'b1;
        if (c == CMD_ACQ) begin
          acq_gnt = 1'b1;
          if (lock_held_o || !wb_empty_i[i]) acq_bad = 1'b1;
        end
        if (c == CMD_REL) begin
          rel_gnt = 1'b1;
          if (!lock_held_o || lock_owner_o != IDX_W'(i) || !wb_empty_i[i]) rel_bad = 1'b1;
        end
        if (c == 3'b111) code_bad = 1'b1;
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_ready_o) && ((cmd_ready_o & ~cmd_valid_i) == '0)); // R1
  AST_LOAD_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni) !load_foreign); // R2
  AST_FENCE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni) !fence_dirty); // R4
  AST_ACQ_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni) !acq_bad); // R5
  AST_ACQ_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_gnt |=> lock_held_o && lock_owner_o == $past(gidx)); // R5
  AST_LOCK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acq_gnt && !rel_gnt |=> $stable(lock_held_o)); // R5
  AST_REL_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni) !rel_bad); // R6
  AST_REL_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni) rel_gnt |=> !lock_held_o); // R6
  AST_DRAIN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_held_o ? (drain_ok_o == owner_hot) : (&drain_ok_o)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) unlock_err_o |=> unlock_err_o); // R9
  AST_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni) !code_bad); // R10
endmodule

bind tso_lock_arbiter tso_lock_arbiter_chk #(.N_CPU(N_CPU)) u_chk (.*);

// File: tb/tso_lock_arbiter_bench.sv
`timescale 1ns/100ps
module tso_lock_arbiter_bench;
  localparam int N = 4;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0]   cmd_valid_i = '0, wb_empty_i = '1;
  logic [3*N-1:0] cmd_type_i = '0;
  logic [N-1:0]   cmd_ready_o, drain_ok_o;
  logic           lock_held_o, unlock_err_o;
  logic [1:0]     lock_owner_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  tso_lock_arbiter #(.N_CPU(N)) u_tso_lock_arbiter (.*);

  // valid, types {c3,c2,c1,c0}, wb_empty, exp ready, exp drain, exp held (after edge), exp owner
  localparam int NV = 12;
  localparam logic [30:0] VEC [NV] = '{
    {4'b1111, 3'd0,3'd0,3'd0,3'd0, 4'b1111, 4'b0001, 4'b1111, 1'b0, 2'd0}, // R2 R8
    {4'b1111, 3'd0,3'd0,3'd0,3'd0, 4'b1111, 4'b0010, 4'b1111, 1'b0, 2'd0}, // R8
    {4'b0011, 3'd0,3'd0,3'd1,3'd5, 4'b1110, 4'b0010, 4'b1111, 1'b0, 2'd0}, // R3 R5 stall
    {4'b0101, 3'd0,3'd0,3'd0,3'd5, 4'b1111, 4'b0100, 4'b1111, 1'b0, 2'd0}, // R8
    {4'b0001, 3'd0,3'd0,3'd0,3'd5, 4'b1111, 4'b0001, 4'b1111, 1'b1, 2'd0}, // R5 take
    {4'b1111, 3'd2,3'd1,3'd0,3'd0, 4'b0111, 4'b0100, 4'b0001, 1'b1, 2'd0}, // R2 R3 R4 R7
    {4'b0011, 3'd0,3'd0,3'd5,3'd0, 4'b1111, 4'b0001, 4'b0001, 1'b1, 2'd0}, // R2 R5
    {4'b1001, 3'd3,3'd0,3'd0,3'd6, 4'b1110, 4'b1000, 4'b0001, 1'b1, 2'd0}, // R3 R6 stall
    {4'b0011, 3'd0,3'd0,3'd5,3'd6, 4'b1111, 4'b0001, 4'b0001, 1'b0, 2'd0}, // R6 free
    {4'b0110, 3'd0,3'd4,3'd5,3'd0, 4'b1111, 4'b0010, 4'b1111, 1'b1, 2'd1}, // R5 R8
    {4'b1000, 3'd7,3'd0,3'd0,3'd0, 4'b1111, 4'b0000, 4'b0010, 1'b1, 2'd1}, // R10
    {4'b0010, 3'd0,3'd0,3'd6,3'd0, 4'b1111, 4'b0010, 4'b0010, 1'b0, 2'd0}  // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] v, input logic [3*N-1:0] t, input logic [N-1:0] e);
    @(negedge clk_i);
    cmd_valid_i = v; cmd_type_i = t; wb_empty_i = e;
    #1;
  endtask

  task automatic after_edge;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    #1;
    chk("R11 held", 32'(lock_held_o), 0);
    chk("R11 err", 32'(unlock_err_o), 0);
    chk("R7 drain", 32'(drain_ok_o), 32'hF);
    rst_ni = 1'b1;

    for (int r = 0; r < NV; r++) begin
      drive(VEC[r][30:27], VEC[r][26:15], VEC[r][14:11]);
      chk($sformatf("R1 R2 R3 R4 R5 R6 R8 R10 ready row%0d", r), 32'(cmd_ready_o), 32'(VEC[r][10:7]));
      chk($sformatf("R7 drain row%0d", r), 32'(drain_ok_o), 32'(VEC[r][6:3]));
      after_edge();
      chk($sformatf("R5 R6 held row%0d", r), 32'(lock_held_o), 32'(VEC[r][2]));
      if (VEC[r][2]) chk($sformatf("R5 owner row%0d", r), 32'(lock_owner_o), 32'(VEC[r][1:0]));
      chk($sformatf("R9 err row%0d", r), 32'(unlock_err_o), 0);
    end

    // R8: rotation from pointer 2 with all eligible
    for (int k = 0; k < N; k++) begin
      drive('1, '0, '1);
      chk("R8 rotation", 32'(cmd_ready_o), 32'(1 << ((k + 2) % N)));
      after_edge();
    end

    // R9: release from non-owner while free
    drive(4'b0100, {3'd0, 3'd6, 3'd0, 3'd0}, '1);
    chk("R9 not accepted", 32'(cmd_ready_o), 0);
    after_edge();
    chk("R9 err set", 32'(unlock_err_o), 1);
    drive('0, '0, '1);
    after_edge();
    chk("R9 err sticky", 32'(unlock_err_o), 1);
    chk("R9 lock untouched", 32'(lock_held_o), 0);

    // R11: reset while lock held
    drive(4'b1000, {3'd5, 3'd0, 3'd0, 3'd0}, '1);
    after_edge();
    chk("R5 owner 3", 32'(lock_owner_o), 3);
    @(negedge clk_i);
    cmd_valid_i = '0;
    rst_ni = 1'b0;
    #1;
    chk("R11 held cleared", 32'(lock_held_o), 0);
    chk("R11 err cleared", 32'(unlock_err_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive('1, '0, '1);
    chk("R11 pointer at 0", 32'(cmd_ready_o), 1);
    after_edge();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule